// File: doc/BRIEF.md
# Overlapping Frame Energy Endpoint Detector

This block takes a stream of 16-bit two's-complement audio samples and measures the energy of each frame. A frame is 256 samples long, and a new frame starts every 128 samples, so each frame shares half its samples with the frame before it. The block sums the squares of each 128-sample half on its own. The energy of a frame is the sum of two neighbouring half sums, divided by 256. Every energy value is compared with a programmable threshold and marked as speech or silence.

A separate tracker keeps the index of the first speech frame and the index of the most recent speech frame. When the end of an utterance is signalled, it reports both indices, or a no-speech flag if no frame crossed the threshold. A new-utterance pulse restarts everything.

Top module: `frame_energy_detector`

## Requirements
- R1: After a synchronous active-low reset, every output is zero.
- R2: A frame's energy equals floor(sum of the squares of its 256 signed samples / 256). The full-scale case is covered by R10.
- R3: Frame k covers accepted samples 128k through 128k+255. The first energy appears after the 256th accepted sample, then one more after every further 128 accepted samples, and energy_valid is never high in two consecutive cycles.
- R4: Only samples with sample_valid high count. If the last sample of a frame is accepted at rising edge k, energy_valid is high for one cycle, from edge k+1 to edge k+2.
- R5: is_speech is high for an emitted frame only when its energy is strictly greater than threshold. An energy equal to the threshold is silence.
- R6: frame_index carries the index of the emitted frame. It starts at 0 after reset or a new utterance and rises by one for each frame.
- R7: word_first is the index of the first speech frame. word_last is the index of the last speech frame seen up to and including the cycle of the end pulse, so a speech frame emitted in that same cycle counts.
- R8: An utt_end pulse sampled at edge e raises report_valid for exactly the cycle after e. The indices and no_speech are updated at that same edge. no_speech is 1, and both indices are 0, when no speech frame occurred.
- R9: utt_start clears the half sums, the sample and frame counters and the endpoint registers, including no_speech and the indices. A sample offered in the same cycle is dropped.
- R10: A frame of 256 samples all equal to -32768 gives energy 2^30 without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_valid | input | 1 | Qualifies sample_data |
| sample_data | input | SAMPLE_W | Signed PCM sample |
| utt_start | input | 1 | New-utterance pulse, clears state |
| utt_end | input | 1 | End-of-utterance pulse, requests a report |
| threshold | input | 2*SAMPLE_W | Energy threshold |
| energy_valid | output | 1 | One-cycle strobe per frame energy |
| energy | output | 2*SAMPLE_W | Frame energy (mean square) |
| is_speech | output | 1 | Emitted frame exceeds threshold |
| frame_index | output | IDX_W | Index of the emitted frame |
| report_valid | output | 1 | One-cycle strobe after utt_end |
| word_first | output | IDX_W | First speech frame index |
| word_last | output | IDX_W | Last speech frame index |
| no_speech | output | 1 | No frame crossed the threshold |

## Verification
A frame's energy strobe and the end-of-utterance pulse can be sampled at the same clock edge. In that case the tracker must count the new frame in the report it builds at that edge. The bench provokes this by watching for energy_valid at a falling edge and raising utt_end right then, where the only speech frame is the one being emitted. It judges the result by requiring report_valid with word_first = word_last = 1 and no_speech low.

// File: rtl/fed_pkg.sv
// Package fed_pkg
// Shared types for the frame energy detector.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package fed_pkg;

    // Tracker state: no speech frame seen yet, or at least one seen.
    typedef enum logic {
        TRK_SILENT = 1'b0,
        TRK_FOUND  = 1'b1
    } trk_state_e;

endpackage

// File: rtl/fed_half_accum.sv
// Module fed_half_accum
// Accumulates the squares of 2**HOP_LOG2 valid samples.
// Publishes the half-frame sum with a one-cycle strobe after the last sample.
// Assumes: clr has priority over a sample offered in the same cycle.
module fed_half_accum #(
    parameter int SAMPLE_W = 16,
    parameter int HOP_LOG2 = 7
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clr,
    input  logic                                in_valid,
    input  logic signed [SAMPLE_W-1:0]          in_data,
    output logic                                half_done,
    output logic [2*SAMPLE_W+HOP_LOG2-1:0]      half_sum
);
    localparam int SQ_W   = 2 * SAMPLE_W;
    localparam int HALF_W = SQ_W + HOP_LOG2;
    localparam logic [HOP_LOG2-1:0] LAST_CNT = '1;

    logic signed [SQ_W-1:0] prod;
    logic [HALF_W-1:0]      sq_ext;
    logic [HOP_LOG2-1:0]    cnt;
    logic [HALF_W-1:0]      acc;

    // Square of the current sample, zero-extended (it is never negative).
    always_comb begin
        prod   = in_data * in_data;
        sq_ext = {{(HALF_W-SQ_W){1'b0}}, prod};
    end

    // Count samples in the half, accumulate squares, publish at the end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt       <= '0;
            acc       <= '0;
            half_done <= 1'b0;
            half_sum  <= '0;
        end else begin
            half_done <= 1'b0;
            if (in_valid) begin
                cnt <= cnt + 1'b1;
                if (cnt == LAST_CNT) begin
                    half_sum  <= acc + sq_ext;
                    half_done <= 1'b1;
                    acc       <= '0;
                end else begin
                    acc <= acc + sq_ext;
                end
            end
        end
    end
endmodule

// File: rtl/fed_frame_combiner.sv
// Module fed_frame_combiner
// Adds the previous and current half sums to form one overlapped frame.
// Divides by the frame length with a shift and classifies against the threshold.
// Assumes: half_done strobes are at least two cycles apart.
module fed_frame_combiner #(
    parameter int SAMPLE_W = 16,
    parameter int HOP_LOG2 = 7,
    parameter int IDX_W    = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr,
    input  logic                             half_done,
    input  logic [2*SAMPLE_W+HOP_LOG2-1:0]   half_sum,
    input  logic [2*SAMPLE_W-1:0]            thresh,
    output logic                             nrg_valid,
    output logic [2*SAMPLE_W-1:0]            nrg_value,
    output logic                             nrg_speech,
    output logic [IDX_W-1:0]                 nrg_frame
);
    localparam int SQ_W        = 2 * SAMPLE_W;
    localparam int HALF_W      = SQ_W + HOP_LOG2;
    localparam int FRAME_LOG2  = HOP_LOG2 + 1;
    localparam int FSUM_W      = HALF_W + 1;
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [HALF_W-1:0] prev_half;
    logic              have_prev;
    logic [IDX_W-1:0]  next_idx;
    logic [FSUM_W-1:0] frame_sum;
    logic [SQ_W-1:0]   energy_next;
    logic              speech_next;

    // Frame sum, its mean and the full-precision threshold test.
    // floor(sum/2^F) > T  is the same as  sum > T*2^F + (2^F - 1).
    always_comb begin
        frame_sum   = {1'b0, prev_half} + {1'b0, half_sum};
        energy_next = frame_sum[FSUM_W-1:FRAME_LOG2];
        speech_next = frame_sum > {1'b0, thresh, {FRAME_LOG2{1'b1}}};
    end

    // Remember the last half and emit a frame once two halves exist.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prev_half  <= '0;
            have_prev  <= 1'b0;
            next_idx   <= '0;
            nrg_valid  <= 1'b0;
            nrg_value  <= '0;
            nrg_speech <= 1'b0;
            nrg_frame  <= '0;
        end else begin
            nrg_valid <= 1'b0;
            if (half_done) begin
                prev_half <= half_sum;
                have_prev <= 1'b1;
                if (have_prev) begin
                    nrg_valid  <= 1'b1;
                    nrg_value  <= energy_next;
                    nrg_speech <= speech_next;
                    nrg_frame  <= next_idx;
                    if (next_idx != IDX_MAX) begin
                        next_idx <= next_idx + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fed_endpoint_tracker.sv
// Module fed_endpoint_tracker
// Tracks the first and latest speech frame indices.
// On an end pulse it publishes them, or raises no_speech.
// Assumes: a frame strobe coinciding with the end pulse belongs to the utterance.
module fed_endpoint_tracker
    import fed_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             nrg_valid,
    input  logic             nrg_speech,
    input  logic [IDX_W-1:0] nrg_frame,
    input  logic             end_pulse,
    output logic             rpt_valid,
    output logic [IDX_W-1:0] rpt_first,
    output logic [IDX_W-1:0] rpt_last,
    output logic             rpt_none
);
    trk_state_e       state;
    logic [IDX_W-1:0] first_q;
    logic [IDX_W-1:0] last_q;
    logic             hit;
    logic             found_n;
    logic [IDX_W-1:0] first_n;
    logic [IDX_W-1:0] last_n;

    // Next endpoint values, folding in a frame arriving this cycle.
    always_comb begin
        hit     = nrg_valid && nrg_speech;
        found_n = (state == TRK_FOUND) || hit;
        first_n = (state == TRK_SILENT && hit) ? nrg_frame : first_q;
        last_n  = hit ? nrg_frame : last_q;
    end

    // Update tracking registers and build the report on an end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state     <= TRK_SILENT;
            first_q   <= '0;
            last_q    <= '0;
            rpt_valid <= 1'b0;
            rpt_first <= '0;
            rpt_last  <= '0;
            rpt_none  <= 1'b0;
        end else begin
            state     <= found_n ? TRK_FOUND : TRK_SILENT;
            first_q   <= first_n;
            last_q    <= last_n;
            rpt_valid <= end_pulse;
            if (end_pulse) begin
                rpt_none  <= !found_n;
                rpt_first <= found_n ? first_n : '0;
                rpt_last  <= found_n ? last_n  : '0;
            end
        end
    end
endmodule

// File: rtl/frame_energy_detector.sv
// Module frame_energy_detector (top)
// Overlapped frame energy with threshold-based word endpoint detection.
// The frame is 2**(HOP_LOG2+1) samples long and advances by 2**HOP_LOG2 samples.
// Assumes: utt_start is a one-cycle pulse and takes priority over samples.
module frame_energy_detector #(
    parameter int SAMPLE_W = 16,
    parameter int HOP_LOG2 = 7,
    parameter int IDX_W    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] sample_data,
    input  logic                       utt_start,
    input  logic                       utt_end,
    input  logic [2*SAMPLE_W-1:0]      threshold,
    output logic                       energy_valid,
    output logic [2*SAMPLE_W-1:0]      energy,
    output logic                       is_speech,
    output logic [IDX_W-1:0]           frame_index,
    output logic                       report_valid,
    output logic [IDX_W-1:0]           word_first,
    output logic [IDX_W-1:0]           word_last,
    output logic                       no_speech
);
    localparam int HALF_W = 2 * SAMPLE_W + HOP_LOG2;

    logic              half_done;
    logic [HALF_W-1:0] half_sum;

    fed_half_accum #(
        .SAMPLE_W (SAMPLE_W),
        .HOP_LOG2 (HOP_LOG2)
    ) u_half (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (utt_start),
        .in_valid  (sample_valid),
        .in_data   (sample_data),
        .half_done (half_done),
        .half_sum  (half_sum)
    );

    fed_frame_combiner #(
        .SAMPLE_W (SAMPLE_W),
        .HOP_LOG2 (HOP_LOG2),
        .IDX_W    (IDX_W)
    ) u_comb (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (utt_start),
        .half_done  (half_done),
        .half_sum   (half_sum),
        .thresh     (threshold),
        .nrg_valid  (energy_valid),
        .nrg_value  (energy),
        .nrg_speech (is_speech),
        .nrg_frame  (frame_index)
    );

    fed_endpoint_tracker #(
        .IDX_W (IDX_W)
    ) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (utt_start),
        .nrg_valid  (energy_valid),
        .nrg_speech (is_speech),
        .nrg_frame  (frame_index),
        .end_pulse  (utt_end),
        .rpt_valid  (report_valid),
        .rpt_first  (word_first),
        .rpt_last   (word_last),
        .rpt_none   (no_speech)
    );
endmodule

// File: rtl/fed_checker.sv
// Module fed_checker
// Protocol and relation checks on the detector's ports, attached by bind.
// Assumes: the checked top keeps its default port names.
module fed_checker #(
    parameter int SAMPLE_W = 16,
    parameter int IDX_W    = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  utt_start,
    input logic                  utt_end,
    input logic [2*SAMPLE_W-1:0] threshold,
    input logic                  energy_valid,
    input logic [2*SAMPLE_W-1:0] energy,
    input logic                  is_speech,
    input logic                  report_valid,
    input logic [IDX_W-1:0]      word_first,
    input logic [IDX_W-1:0]      word_last,
    input logic                  no_speech
);
    localparam logic [2*SAMPLE_W-1:0] E_MAX = 1 << (2*SAMPLE_W - 2);

    p_no_back_to_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        energy_valid |=> !energy_valid);

    p_speech_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (energy_valid && $stable(threshold)) |-> (is_speech == (energy > threshold)));

    p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !no_speech |-> (word_first <= word_last));

    p_report_follows_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (utt_end && !utt_start) |=> report_valid);

    p_report_needs_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        report_valid |-> $past(utt_end));

    p_none_zero_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        no_speech |-> (word_first == '0 && word_last == '0));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        utt_start |=> (!energy_valid && !report_valid && !no_speech
                       && word_first == '0 && word_last == '0));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        energy_valid |-> (energy <= E_MAX));
endmodule

bind frame_energy_detector fed_checker #(
    .SAMPLE_W (SAMPLE_W),
    .IDX_W    (IDX_W)
) u_fed_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .utt_start    (utt_start),
    .utt_end      (utt_end),
    .threshold    (threshold),
    .energy_valid (energy_valid),
    .energy       (energy),
    .is_speech    (is_speech),
    .report_valid (report_valid),
    .word_first   (word_first),
    .word_last    (word_last),
    .no_speech    (no_speech)
);

// File: tb/tb_frame_energy_detector.sv
// Bench for frame_energy_detector: a table walk, then directed corner cases.
module tb_frame_energy_detector;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sample_valid = 1'b0;
    logic signed [15:0] sample_data = '0;
    logic               utt_start = 1'b0;
    logic               utt_end = 1'b0;
    logic [31:0]        threshold = 32'd1000000;
    logic               energy_valid;
    logic [31:0]        energy;
    logic               is_speech;
    logic [11:0]        frame_index;
    logic               report_valid;
    logic [11:0]        word_first;
    logic [11:0]        word_last;
    logic               no_speech;

    frame_energy_detector dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_data  (sample_data),
        .utt_start    (utt_start),
        .utt_end      (utt_end),
        .threshold    (threshold),
        .energy_valid (energy_valid),
        .energy       (energy),
        .is_speech    (is_speech),
        .frame_index  (frame_index),
        .report_valid (report_valid),
        .word_first   (word_first),
        .word_last    (word_last),
        .no_speech    (no_speech)
    );

    always #10 clk = ~clk;

    // Half amplitudes (samples alternate +a/-a), valid-gap flags, expected energies.
    localparam int     AMP   [9] = '{0, 100, 3000, 3000, 200, 20000, 5, 0, 32767};
    localparam bit     GAP   [9] = '{0, 0, 1, 0, 0, 1, 0, 0, 0};
    localparam longint EXP_E [8] = '{5000, 4505000, 9000000, 4520000,
                                     200020000, 200000012, 12, 536838144};

    int     n_chk = 0;
    int     n_bad = 0;
    int     cyc   = 0;
    int     n_em  = 0;
    longint em_val [64];
    int     em_idx [64];
    bit     em_sp  [64];
    int     em_cyc [64];
    int     acc_cyc [16];
    bit     finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Record every energy strobe shortly after the edge that raises it.
    always @(posedge clk) begin
        #2;
        if (energy_valid && n_em < 64) begin
            em_val[n_em] = longint'(energy);
            em_idx[n_em] = int'(frame_index);
            em_sp[n_em]  = is_speech;
            em_cyc[n_em] = cyc;
            n_em = n_em + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive n alternating samples of amplitude amp, optionally with valid-low gaps.
    task automatic send(input int amp, input int n, input bit gaps, input int slot);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 16 == 5)) begin
                sample_valid = 1'b0;
                sample_data  = 16'sh7fff;
                @(negedge clk);
            end
            sample_valid  = 1'b1;
            sample_data   = (i % 2 == 0) ? 16'(amp) : 16'(-amp);
            acc_cyc[slot] = cyc + 1;
            @(negedge clk);
        end
        sample_valid = 1'b0;
        sample_data  = '0;
    endtask

    task automatic new_utt(input bit with_sample);
        utt_start    = 1'b1;
        sample_valid = with_sample;
        sample_data  = 16'sh7fff;
        @(negedge clk);
        utt_start    = 1'b0;
        sample_valid = 1'b0;
        sample_data  = '0;
        n_em = 0;
    endtask

    task automatic end_utt();
        utt_end = 1'b1;
        @(negedge clk);
        utt_end = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!energy_valid && !report_valid && !no_speech && energy == 0
            && word_first == 0 && word_last == 0 && frame_index == 0,
            "R1 reset outputs", longint'(energy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 R3 R4 R5 R6
        n_em = 0;
        for (int h = 0; h < 9; h++) send(AMP[h], 128, GAP[h], h);
        repeat (4) @(negedge clk);
        chk(n_em == 8, "R3 frame count", n_em, 8);
        for (int f = 0; f < 8; f++) begin
            chk(em_val[f] == EXP_E[f], "R2 energy", em_val[f], EXP_E[f]);
            chk(em_idx[f] == f, "R6 frame index", em_idx[f], f);
            chk(em_sp[f] == (EXP_E[f] > 1000000), "R5 speech flag",
                em_sp[f], (EXP_E[f] > 1000000));
            chk(em_cyc[f] == acc_cyc[f+1] + 1, "R4 energy timing",
                em_cyc[f], acc_cyc[f+1] + 1);
        end
        end_utt();
        chk(report_valid == 1'b1, "R8 report strobe", report_valid, 1);
        chk(word_first == 1, "R7 first speech frame", word_first, 1);
        chk(word_last == 7, "R7 last speech frame", word_last, 7);
        chk(no_speech == 1'b0, "R8 speech present", no_speech, 0);
        @(negedge clk);
        chk(report_valid == 1'b0, "R8 strobe one cycle", report_valid, 0);

        // Threshold equality is silence, report says no speech: R5 R8
        new_utt(1'b0);
        threshold = 32'd9000000;
        for (int h = 0; h < 3; h++) send(3000, 128, 1'b0, h);
        repeat (4) @(negedge clk);
        chk(n_em == 2, "R3 frame count equal case", n_em, 2);
        for (int f = 0; f < 2; f++) begin
            chk(em_sp[f] == 1'b0, "R5 equal threshold is silence", em_sp[f], 0);
            chk(em_val[f] == 9000000, "R2 energy equal case", em_val[f], 9000000);
        end
        end_utt();
        chk(report_valid && no_speech, "R8 no speech flag", no_speech, 1);
        chk(word_first == 0 && word_last == 0, "R8 indices zero", word_last, 0);

        // Clear mid-frame, clear beats a same-cycle sample: R9
        threshold = 32'd1000000;
        new_utt(1'b0);
        chk(no_speech == 1'b0, "R9 no_speech cleared", no_speech, 0);
        send(32767, 64, 1'b0, 0);
        new_utt(1'b1);
        send(100, 128, 1'b0, 0);
        send(100, 128, 1'b0, 1);
        repeat (4) @(negedge clk);
        chk(n_em == 1, "R9 frame count after clear", n_em, 1);
        chk(em_val[0] == 10000, "R9 partial sum cleared", em_val[0], 10000);
        chk(em_idx[0] == 0, "R9 frame counter cleared", em_idx[0], 0);

        // Full-scale negative samples: R10
        new_utt(1'b0);
        send(32768, 128, 1'b0, 0);
        send(32768, 128, 1'b0, 1);
        repeat (4) @(negedge clk);
        chk(n_em == 1 && em_val[0] == 64'd1073741824, "R10 full scale energy",
            em_val[0], 64'd1073741824);

        // End pulse in the same cycle as a speech frame: R7
        new_utt(1'b0);
        send(0, 128, 1'b0, 0);
        send(0, 128, 1'b0, 1);
        send(3000, 128, 1'b0, 2);
        @(negedge clk);
        chk(energy_valid && is_speech, "R4 strobe before same-cycle end",
            energy_valid, 1);
        end_utt();
        chk(report_valid == 1'b1, "R8 report on coinciding end", report_valid, 1);
        chk(no_speech == 1'b0, "R7 coinciding frame counted", no_speech, 0);
        chk(word_first == 1 && word_last == 1, "R7 coinciding indices", word_last, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule